// File: doc/BRIEF.md
# Programmable Defect Condition Detector

This block watches a wide bus of tapped processor status lines and raises a one-cycle match pulse when a programmed defect condition appears. Each of several signature slots holds its own configuration. That configuration has three parts. The first is a set of lane selectors that pull a small subset of the taps into the slot. The second is a sum-of-products program over those lanes, split into ordered stages. The third is a control word that gives the slot's valid bit, its matching mode, its timing class (the condition shows up before or after the erroneous effect), the index of its last stage and a defect-class identifier.

A slot in same-cycle mode fires when its stage-0 expression becomes true. A slot in sequence mode steps through its stages in order, taking one stage per cycle at most. It falls back to idle if the next stage does not arrive within a programmable window of cycles. The configuration is written through a flat register port, so a signature loaded in the field reprograms the whole slot. The winning pulse goes to a recovery controller and carries the slot index, the class identifier and the timing-class bit.

Top module: `defect_cond_detector`

## Requirements
- R1: While `rst_n` is low, every output is zero and every slot's configuration is cleared. A cleared slot is invalid, so after reset no tap pattern produces a match until the slot is programmed again.
- R2: A slot's lane i carries `taps[k]`, where k is the lane's selector (register 2+i, bits [IDX_W-1:0]). A selector at or above NUM_TAPS makes the lane read 0.
- R3: Term register 2+SEL_W+stage*NUM_TERMS+term holds a care mask in bits [SEL_W-1:0] and a wanted value in bits [2*SEL_W-1:SEL_W]. A term is true when every cared lane equals its wanted bit. A term whose care mask is zero is never true. A stage is true when any of its terms is true.
- R4: In same-cycle mode (control bit 1 = 0), a slot fires only on a cycle where stage 0 is true and stage 0 was not true in the slot's previous enabled cycle. `match_o` pulses in the cycle after that tap sample.
- R5: In sequence mode (control bit 1 = 1), stages 0 up to the last stage (control bits [4+STG_W-1:4]) must be true in that order, with at most one stage taken per cycle. A stage seen out of order is ignored. The pulse follows the sample that completes the last stage, and the slot then returns to idle.
- R6: With a timeout T > 0 (register 1), each stage after stage 0 must be true within the T cycles that follow the previous stage. If it is not, the slot drops back to waiting for stage 0.
- R7: A timeout of 0 lets a sequence wait forever between stages.
- R8: A slot whose valid bit (control bit 0) is clear never fires. While `det_en` is low, no slot fires and all sequence progress and edge history is discarded.
- R9: A configuration write to a slot discards that slot's sequence progress and edge history during that cycle.
- R10: When several slots fire in the same cycle, the lowest index wins. The pulse carries the slot index, the class id (control bits [8+CLS_W-1:8]) and the timing bit (control bit 2, 1 = post-defect).
- R11: In a cycle without a pulse, `match_slot`, `match_class` and `match_post` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| det_en | input | 1 | Global detection enable |
| taps | input | NUM_TAPS | Tapped status signals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot being written |
| cfg_reg | input | REG_W | Register index within the slot |
| cfg_wdata | input | 2*SEL_W | Write data |
| match_o | output | 1 | One-cycle defect match pulse |
| match_slot | output | SLOT_W | Index of the winning slot |
| match_class | output | CLS_W | Class identifier of the winning slot |
| match_post | output | 1 | Timing class of the winning slot (1 = post-defect) |

## Verification
Each result appears one cycle after the sample that causes it. The tap value driven in a cycle is evaluated by the selection and product logic, and then a single output register carries the pulse. The bench therefore drives the taps on the falling edge and checks all four outputs just after the following rising edge. A configuration write takes effect at the edge that stores it, so the bench always judges the first sample after that edge under the new configuration. The timeout rows count the idle cycles that follow a stage advance, so that both the last cycle allowed by the window and the cycle after it are checked.

// File: rtl/det_pkg.sv
// Shared definitions for the defect condition detector.
// Assumes the control word has room for its fields at the listed offsets.
package det_pkg;
    typedef enum logic {
        COND_SAME = 1'b0,   // all required lanes in the same cycle
        COND_SEQ  = 1'b1    // ordered stages over several cycles
    } cond_mode_e;

    // Control word field offsets
    localparam int CTL_VALID   = 0;
    localparam int CTL_MODE    = 1;
    localparam int CTL_POST    = 2;
    localparam int CTL_LAST_LO = 4;
    localparam int CTL_CLS_LO  = 8;

    // Register indices within one slot
    localparam int REG_CTRL  = 0;
    localparam int REG_TMO   = 1;
    localparam int REG_LANE0 = 2;
endpackage

// File: rtl/det_slot_cfg.sv
// Signature storage for one slot: control word, timeout, lane selectors
// and product-term masks. Assumes wr_en is already decoded for this slot.
module det_slot_cfg
    import det_pkg::*;
#(
    parameter int SEL_W      = 8,
    parameter int NUM_STAGES = 4,
    parameter int NUM_TERMS  = 2,
    parameter int IDX_W      = 7,
    parameter int TMO_W      = 12,
    parameter int CLS_W      = 4,
    parameter int REG_W      = 5,
    localparam int STG_W     = $clog2(NUM_STAGES),
    localparam int CFG_W     = 2 * SEL_W,
    localparam int NTERM_ALL = NUM_STAGES * NUM_TERMS,
    localparam int REG_TERM0 = REG_LANE0 + SEL_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [REG_W-1:0]              wr_reg,
    input  logic [CFG_W-1:0]              wr_data,
    output logic                          valid_o,
    output cond_mode_e                    mode_o,
    output logic                          post_o,
    output logic [STG_W-1:0]              last_o,
    output logic [CLS_W-1:0]              class_o,
    output logic [TMO_W-1:0]              tmo_o,
    output logic [SEL_W*IDX_W-1:0]        lane_idx_o,
    output logic [NTERM_ALL*SEL_W-1:0]    care_o,
    output logic [NTERM_ALL*SEL_W-1:0]    want_o
);

    // Stores the control word fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            mode_o  <= COND_SAME;
            post_o  <= 1'b0;
            last_o  <= '0;
            class_o <= '0;
        end else if (wr_en && wr_reg == REG_W'(REG_CTRL)) begin
            valid_o <= wr_data[CTL_VALID];
            mode_o  <= cond_mode_e'(wr_data[CTL_MODE]);
            post_o  <= wr_data[CTL_POST];
            last_o  <= wr_data[CTL_LAST_LO +: STG_W];
            class_o <= wr_data[CTL_CLS_LO +: CLS_W];
        end
    end

    // Stores the inter-stage timeout window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_o <= '0;
        end else if (wr_en && wr_reg == REG_W'(REG_TMO)) begin
            tmo_o <= wr_data[TMO_W-1:0];
        end
    end

    for (genvar i = 0; i < SEL_W; i++) begin : g_lane
        localparam int RIDX = REG_LANE0 + i;
        // Stores the tap selector of lane i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_idx_o[i*IDX_W +: IDX_W] <= '0;
            end else if (wr_en && wr_reg == REG_W'(RIDX)) begin
                lane_idx_o[i*IDX_W +: IDX_W] <= wr_data[IDX_W-1:0];
            end
        end
    end

    for (genvar t = 0; t < NTERM_ALL; t++) begin : g_term
        localparam int RIDX = REG_TERM0 + t;
        // Stores the care mask and wanted value of product term t
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                care_o[t*SEL_W +: SEL_W] <= '0;
                want_o[t*SEL_W +: SEL_W] <= '0;
            end else if (wr_en && wr_reg == REG_W'(RIDX)) begin
                care_o[t*SEL_W +: SEL_W] <= wr_data[SEL_W-1:0];
                want_o[t*SEL_W +: SEL_W] <= wr_data[CFG_W-1:SEL_W];
            end
        end
    end

endmodule

// File: rtl/det_lane_sel.sv
// Selection stage: each lane picks one tap by index. Indices past the
// last tap read as 0 through a zero-padded copy of the tap bus.
module det_lane_sel #(
    parameter int NUM_TAPS = 64,
    parameter int SEL_W    = 8,
    parameter int IDX_W    = 7,
    localparam int PAD_N   = (1 << IDX_W) - NUM_TAPS
) (
    input  logic [NUM_TAPS-1:0]    taps,
    input  logic [SEL_W*IDX_W-1:0] lane_idx,
    output logic [SEL_W-1:0]       lanes
);
    logic [(1<<IDX_W)-1:0] taps_pad;

    // Widens the tap bus so every index value addresses a defined bit
    always_comb taps_pad = {{PAD_N{1'b0}}, taps};

    for (genvar i = 0; i < SEL_W; i++) begin : g_mux
        // Picks the tap for lane i
        always_comb lanes[i] = taps_pad[lane_idx[i*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/det_sop_eval.sv
// Sum-of-products evaluation: per stage, an OR of masked-compare terms.
// A term with an empty care mask is treated as unprogrammed and stays false.
module det_sop_eval #(
    parameter int SEL_W      = 8,
    parameter int NUM_STAGES = 4,
    parameter int NUM_TERMS  = 2,
    localparam int NTERM_ALL = NUM_STAGES * NUM_TERMS
) (
    input  logic [SEL_W-1:0]           lanes,
    input  logic [NTERM_ALL*SEL_W-1:0] care,
    input  logic [NTERM_ALL*SEL_W-1:0] want,
    output logic [NUM_STAGES-1:0]      stage_hit
);
    logic [NTERM_ALL-1:0] term_hit;

    for (genvar t = 0; t < NTERM_ALL; t++) begin : g_term
        // Product term t: all cared lanes equal their wanted bits
        always_comb term_hit[t] = (|care[t*SEL_W +: SEL_W]) &&
            (((lanes ^ want[t*SEL_W +: SEL_W]) & care[t*SEL_W +: SEL_W]) == '0);
    end

    for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
        // Stage s is the OR of its terms
        always_comb stage_hit[s] = |term_hit[s*NUM_TERMS +: NUM_TERMS];
    end
endmodule

// File: rtl/det_seq_fsm.sv
// Per-slot matcher. Same-cycle mode fires on a rising stage-0 result;
// sequence mode walks the stages in order under an inter-stage timeout.
// Assumes NUM_STAGES is a power of two so a stage index always names a stage.
module det_seq_fsm
    import det_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    parameter int TMO_W      = 12,
    localparam int STG_W     = $clog2(NUM_STAGES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,        // enabled and slot valid
    input  logic                  clr,        // configuration write this cycle
    input  cond_mode_e            mode,
    input  logic [STG_W-1:0]      last,
    input  logic [TMO_W-1:0]      tmo,
    input  logic [NUM_STAGES-1:0] stage_hit,
    output logic                  hit_o
);
    logic             active_q;
    logic [STG_W-1:0] idx_q;
    logic [TMO_W-1:0] tmr_q;
    logic             prev_q;
    logic             live, seq_mode, cur, at_last;

    // Current stage result and whether it completes the condition
    always_comb begin
        live     = run && !clr;
        seq_mode = (mode == COND_SEQ);
        cur      = active_q ? stage_hit[idx_q] : stage_hit[0];
        at_last  = active_q ? (idx_q == last) : (last == '0);
        hit_o    = live && (seq_mode ? (cur && at_last)
                                     : (stage_hit[0] && !prev_q));
    end

    // Stage walker with inter-stage timeout
    always_ff @(posedge clk) begin
        if (!rst_n || !live || !seq_mode) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            tmr_q    <= '0;
        end else if (cur) begin
            tmr_q <= '0;
            if (at_last) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                active_q <= 1'b1;
                idx_q    <= idx_q + 1'b1;
            end
        end else if (active_q && tmo != '0) begin
            if (tmr_q == tmo - 1'b1) begin
                active_q <= 1'b0;
                idx_q    <= '0;
                tmr_q    <= '0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    // Edge history for same-cycle mode
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= live && !seq_mode && stage_hit[0];
    end

    // R5: an active walker always points at a stage beyond 0 and not past the last
    p_stage_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (idx_q != '0 && idx_q <= last));

    // R6: the window counter never reaches the programmed timeout
    p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && tmo != '0) |-> (tmr_q < tmo));

    // R9: a write to the slot leaves no progress behind
    p_write_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!active_q && !prev_q));

    // R8: a disabled or invalid slot holds no progress
    p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !active_q);
endmodule

// File: rtl/defect_cond_detector.sv
// Top: a set of signature slots, each with storage, lane selection, term
// evaluation and a matcher, followed by a lowest-index-wins priority pick
// and one output register stage.
module defect_cond_detector
    import det_pkg::*;
#(
    parameter int NUM_TAPS   = 64,
    parameter int SEL_W      = 8,
    parameter int NUM_SLOTS  = 4,
    parameter int NUM_STAGES = 4,
    parameter int NUM_TERMS  = 2,
    parameter int TMO_W      = 12,
    parameter int CLS_W      = 4,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int IDX_W     = $clog2(NUM_TAPS) + 1,
    localparam int STG_W     = $clog2(NUM_STAGES),
    localparam int CFG_W     = 2 * SEL_W,
    localparam int NTERM_ALL = NUM_STAGES * NUM_TERMS,
    localparam int NUM_REGS  = REG_LANE0 + SEL_W + NTERM_ALL,
    localparam int REG_W     = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                det_en,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                cfg_we,
    input  logic [SLOT_W-1:0]   cfg_slot,
    input  logic [REG_W-1:0]    cfg_reg,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic                match_o,
    output logic [SLOT_W-1:0]   match_slot,
    output logic [CLS_W-1:0]    match_class,
    output logic                match_post
);
    logic [NUM_SLOTS-1:0] slot_hit;
    logic [CLS_W-1:0]     cls_a  [NUM_SLOTS];
    logic                 post_a [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic                       wr_hit, valid, post;
        cond_mode_e                 mode;
        logic [STG_W-1:0]           last;
        logic [CLS_W-1:0]           cls;
        logic [TMO_W-1:0]           tmo;
        logic [SEL_W*IDX_W-1:0]     lane_idx;
        logic [NTERM_ALL*SEL_W-1:0] care, want;
        logic [SEL_W-1:0]           lanes;
        logic [NUM_STAGES-1:0]      stage_hit;

        // Decodes configuration writes aimed at slot s
        always_comb wr_hit = cfg_we && (cfg_slot == SLOT_W'(s));

        det_slot_cfg #(
            .SEL_W(SEL_W), .NUM_STAGES(NUM_STAGES), .NUM_TERMS(NUM_TERMS),
            .IDX_W(IDX_W), .TMO_W(TMO_W), .CLS_W(CLS_W), .REG_W(REG_W)
        ) u_cfg (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .wr_reg(cfg_reg),
            .wr_data(cfg_wdata), .valid_o(valid), .mode_o(mode),
            .post_o(post), .last_o(last), .class_o(cls), .tmo_o(tmo),
            .lane_idx_o(lane_idx), .care_o(care), .want_o(want)
        );

        det_lane_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_sel (
            .taps(taps), .lane_idx(lane_idx), .lanes(lanes)
        );

        det_sop_eval #(.SEL_W(SEL_W), .NUM_STAGES(NUM_STAGES),
                       .NUM_TERMS(NUM_TERMS)) u_sop (
            .lanes(lanes), .care(care), .want(want), .stage_hit(stage_hit)
        );

        det_seq_fsm #(.NUM_STAGES(NUM_STAGES), .TMO_W(TMO_W)) u_fsm (
            .clk(clk), .rst_n(rst_n), .run(det_en && valid), .clr(wr_hit),
            .mode(mode), .last(last), .tmo(tmo), .stage_hit(stage_hit),
            .hit_o(slot_hit[s])
        );

        // Exposes the slot's tag fields to the priority pick
        always_comb begin
            cls_a[s]  = cls;
            post_a[s] = post;
        end
    end

    logic              win;
    logic [SLOT_W-1:0] win_idx;
    logic [CLS_W-1:0]  win_cls;
    logic              win_post;

    // Lowest-indexed firing slot wins; fields are zero when none fires
    always_comb begin
        win      = 1'b0;
        win_idx  = '0;
        win_cls  = '0;
        win_post = 1'b0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (slot_hit[s]) begin
                win      = 1'b1;
                win_idx  = SLOT_W'(s);
                win_cls  = cls_a[s];
                win_post = post_a[s];
            end
        end
    end

    // Output register: one pulse per firing cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o     <= 1'b0;
            match_slot  <= '0;
            match_class <= '0;
            match_post  <= 1'b0;
        end else begin
            match_o     <= win;
            match_slot  <= win_idx;
            match_class <= win_cls;
            match_post  <= win_post;
        end
    end

    logic [NUM_SLOTS-1:0] below_win;
    // Mask of slots with a lower index than the reported one (checker only)
    always_comb below_win = (NUM_SLOTS'(1) << match_slot) - 1'b1;

    // R10: the reported slot fired and no lower slot did
    p_lowest_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ((($past(slot_hit) & below_win) == '0) &&
                     (($past(slot_hit) >> match_slot) & NUM_SLOTS'(1)) != '0));

    // R8: no pulse follows a disabled cycle
    p_off_no_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !match_o);

    // R11: tag fields are quiet without a pulse
    p_quiet_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (match_slot == '0 && match_class == '0 && !match_post));
endmodule

// File: tb/tb_defect_cond_detector.sv
module tb_defect_cond_detector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        det_en = 1'b1;
    logic [63:0] taps = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [4:0]  cfg_reg = '0;
    logic [15:0] cfg_wdata = '0;
    logic        match_o;
    logic [1:0]  match_slot;
    logic [3:0]  match_class;
    logic        match_post;

    int n_run = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    defect_cond_detector dut (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .taps(taps),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .match_o(match_o), .match_slot(match_slot),
        .match_class(match_class), .match_post(match_post)
    );

    typedef struct packed {
        logic [63:0] t;
        logic        m;
        logic [1:0]  s;
        logic [3:0]  c;
        logic        p;
    } vec_t;

    // Slot0 same-cycle (tap0&tap1 | tap2&!tap3, class 5 pre); slot1 sequence
    // tap8 -> tap9 -> tap10&tap11, window 3, class 9 post; slot2 same-cycle
    // on tap0, class 3 post, with a term on an out-of-range lane.
    localparam vec_t VEC [36] = '{
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 0  R11 idle
        '{64'h1,   1'b1, 2'd2, 4'd3, 1'b1},  // 1  R4 slot2 rises
        '{64'h3,   1'b1, 2'd0, 4'd5, 1'b0},  // 2  R3 slot0 term0
        '{64'h3,   1'b0, 2'd0, 4'd0, 1'b0},  // 3  R4 held, no repeat
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 4
        '{64'h3,   1'b1, 2'd0, 4'd5, 1'b0},  // 5  R10 slot0 beats slot2
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 6
        '{64'hC,   1'b0, 2'd0, 4'd0, 1'b0},  // 7  R3 wanted-zero lane set
        '{64'h4,   1'b1, 2'd0, 4'd5, 1'b0},  // 8  R3 second term
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 9
        '{64'h100, 1'b0, 2'd0, 4'd0, 1'b0},  // 10 R5 stage0
        '{64'h200, 1'b0, 2'd0, 4'd0, 1'b0},  // 11 R5 stage1
        '{64'hC00, 1'b1, 2'd1, 4'd9, 1'b1},  // 12 R5 last stage
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 13
        '{64'h200, 1'b0, 2'd0, 4'd0, 1'b0},  // 14 R5 out of order
        '{64'hC00, 1'b0, 2'd0, 4'd0, 1'b0},  // 15 R5 out of order
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 16
        '{64'h100, 1'b0, 2'd0, 4'd0, 1'b0},  // 17 R6 stage0
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 18
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 19
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 20 R6 window expires
        '{64'h200, 1'b0, 2'd0, 4'd0, 1'b0},  // 21 R6 too late
        '{64'hC00, 1'b0, 2'd0, 4'd0, 1'b0},  // 22 R6 no match
        '{64'h100, 1'b0, 2'd0, 4'd0, 1'b0},  // 23
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 24
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 25
        '{64'h200, 1'b0, 2'd0, 4'd0, 1'b0},  // 26 R6 last window cycle
        '{64'hC00, 1'b1, 2'd1, 4'd9, 1'b1},  // 27 R6 match
        '{64'hF00, 1'b0, 2'd0, 4'd0, 1'b0},  // 28 R5 one stage per cycle
        '{64'hF00, 1'b0, 2'd0, 4'd0, 1'b0},  // 29
        '{64'hF00, 1'b1, 2'd1, 4'd9, 1'b1},  // 30 R5 third cycle fires
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 31
        '{64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 2'd0, 4'd0, 1'b0}, // 32 R2 lane out of range
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 33
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0},  // 34
        '{64'h0,   1'b0, 2'd0, 4'd0, 1'b0}   // 35
    };

    task automatic chk(input logic em, input logic [1:0] es, input logic [3:0] ec,
                       input logic ep, input string tag);
        n_run++;
        if (match_o !== em || match_slot !== es || match_class !== ec || match_post !== ep) begin
            n_fail++;
            $display("FAIL %s: got m=%0b slot=%0d cls=%0d post=%0b, expected m=%0b slot=%0d cls=%0d post=%0b",
                     tag, match_o, match_slot, match_class, match_post, em, es, ec, ep);
        end
    endtask

    task automatic step(input logic [63:0] v, input logic em, input logic [1:0] es,
                        input logic [3:0] ec, input logic ep, input string tag);
        @(negedge clk);
        taps = v;
        @(posedge clk);
        #1;
        chk(em, es, ec, ep, tag);
    endtask

    task automatic wr(input logic [1:0] s, input int r, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = s; cfg_reg = 5'(r); cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] ctl(input logic v, input logic sq, input logic po,
                                        input logic [1:0] last, input logic [3:0] c);
        return {4'd0, c, 2'd0, last, 1'b0, po, sq, v};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected fewer than 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(1'b0, 2'd0, 4'd0, 1'b0, "R1 outputs in reset");
        @(negedge clk);
        rst_n = 1'b1;

        // slot0
        for (int i = 0; i < 8; i++) wr(2'd0, 2 + i, 16'(i));
        wr(2'd0, 10, 16'h0303);
        wr(2'd0, 11, 16'h040C);
        wr(2'd0, 0, ctl(1'b1, 1'b0, 1'b0, 2'd0, 4'd5));
        // slot1
        for (int i = 0; i < 8; i++) wr(2'd1, 2 + i, 16'(8 + i));
        wr(2'd1, 10, 16'h0101);
        wr(2'd1, 12, 16'h0202);
        wr(2'd1, 14, 16'h0C0C);
        wr(2'd1, 1, 16'd3);
        wr(2'd1, 0, ctl(1'b1, 1'b1, 1'b1, 2'd2, 4'd9));
        // slot2
        wr(2'd2, 2, 16'd16);
        wr(2'd2, 3, 16'd0);
        wr(2'd2, 9, 16'd70);
        wr(2'd2, 10, 16'h8181);
        wr(2'd2, 11, 16'h0202);
        wr(2'd2, 0, ctl(1'b1, 1'b0, 1'b1, 2'd0, 4'd3));
        // slot3: programmed for tap40 but left invalid
        wr(2'd3, 2, 16'd40);
        wr(2'd3, 10, 16'h0101);
        wr(2'd3, 0, ctl(1'b0, 1'b0, 1'b0, 2'd0, 4'd7));

        for (int i = 0; i < 36; i++)
            step(VEC[i].t, VEC[i].m, VEC[i].s, VEC[i].c, VEC[i].p,
                 $sformatf("table row %0d", i));

        // R8: disabled cycle, then re-enable with the condition held
        det_en = 1'b0;
        step(64'h1, 1'b0, 2'd0, 4'd0, 1'b0, "R8 disabled");
        det_en = 1'b1;
        step(64'h1, 1'b1, 2'd2, 4'd3, 1'b1, "R8 re-enabled edge");
        step(64'h0, 1'b0, 2'd0, 4'd0, 1'b0, "R8 idle");

        // R8: disabling drops sequence progress
        step(64'h100, 1'b0, 2'd0, 4'd0, 1'b0, "R8 stage0");
        det_en = 1'b0;
        step(64'h0, 1'b0, 2'd0, 4'd0, 1'b0, "R8 off");
        det_en = 1'b1;
        step(64'h200, 1'b0, 2'd0, 4'd0, 1'b0, "R8 stage1 lost");
        step(64'hC00, 1'b0, 2'd0, 4'd0, 1'b0, "R8 no match after drop");

        // R9: a configuration write drops progress
        step(64'h100, 1'b0, 2'd0, 4'd0, 1'b0, "R9 stage0");
        step(64'h200, 1'b0, 2'd0, 4'd0, 1'b0, "R9 stage1");
        wr(2'd1, 1, 16'd3);
        step(64'hC00, 1'b0, 2'd0, 4'd0, 1'b0, "R9 no match after write");

        // R7: zero timeout waits forever
        wr(2'd1, 1, 16'd0);
        step(64'h100, 1'b0, 2'd0, 4'd0, 1'b0, "R7 stage0");
        for (int i = 0; i < 10; i++) step(64'h0, 1'b0, 2'd0, 4'd0, 1'b0, "R7 wait");
        step(64'h200, 1'b0, 2'd0, 4'd0, 1'b0, "R7 stage1");
        step(64'hC00, 1'b1, 2'd1, 4'd9, 1'b1, "R7 late match");
        step(64'h0, 1'b0, 2'd0, 4'd0, 1'b0, "R7 idle");

        // R8: invalid slot stays silent, then fires once made valid
        step(64'h100_0000_0000, 1'b0, 2'd0, 4'd0, 1'b0, "R8 invalid slot");
        wr(2'd3, 0, ctl(1'b1, 1'b0, 1'b0, 2'd0, 4'd7));
        step(64'h100_0000_0000, 1'b1, 2'd3, 4'd7, 1'b0, "R8 valid slot fires R10 fields");

        // R1: reset clears the store
        @(negedge clk);
        rst_n = 1'b0;
        taps = 64'h1;
        @(posedge clk);
        #1;
        chk(1'b0, 2'd0, 4'd0, 1'b0, "R1 reset mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        step(64'h1, 1'b0, 2'd0, 4'd0, 1'b0, "R1 store cleared");
        step(64'h3, 1'b0, 2'd0, 4'd0, 1'b0, "R1 store cleared");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule